// File: doc/BRIEF.md
# Multiplexed 16-bit Bus Slave Bridge

This block is a slave on an external synchronous bus whose address and data share one 16-bit path. Each external access moves one 32-bit word in two 16-bit beats, low half first, and the bridge turns that access into one internal register access. The internal side sees a register index, a write word with a one-cycle write strobe, and a one-cycle read strobe that is answered by the read-data input.

A bus cycle opens when the master pulls chip select low. On the first rising bus-clock edge with the address strobe low, the bridge decodes the address word. Bits 15:4 select the block and bits 3:2 pick one of four registers. Bits 1:0 are not used. Only a block-select match makes the bridge respond. On reads it holds the wait line low while the internal read completes. It then drives the two halves on consecutive clock edges. The shared path is exposed as a separate input, output and output-enable, so a pad tristate buffer can be placed at the chip boundary. Everything runs on the bus clock.

Top module: `mux_bus_slave`

## Requirements
- R1: After synchronous reset, `bus_wait_n` is 1, `bus_ad_oe` is 0 and both internal strobes are 0.
- R2: The address word is taken at the first rising edge with `bus_cs_n` and `bus_adv_n` low. The access is accepted only if bits 15:4 equal `BLOCK_ID`. Bits 3:2 then appear on `reg_idx` from the following cycle.
- R3: On a write (`bus_we_n` low at the address edge), the low half is taken at the next edge and the high half at the edge after that. `reg_wr` is high for exactly the one cycle after the high-half edge, with `reg_wdata` = {high, low}.
- R4: On an accepted read, `reg_rd` is high for exactly the one cycle after the address edge.
- R5: On an accepted read, `bus_wait_n` goes low after the address edge and rises after edge number `RD_LAT` counted from it.
- R6: `reg_rdata` is sampled at edge number `RD_LAT` after the address edge. Its low half is on `bus_ad_out` after that edge and its high half after the next one.
- R7: `bus_ad_oe` is 1 only during the two read data beats, and only while `bus_cs_n` and `bus_oe_n` are both low. It is 0 again after the high-half beat.
- R8: An access whose block field does not match fires no strobe, never drives the path and leaves `bus_wait_n` high. Register contents are unchanged.
- R9: `bus_cs_n` high at any rising edge ends the access. Wait and the output drive are released, and the next access starts normally.
- R10: Only one access is performed per chip-select low period. Further address strobes are ignored until `bus_cs_n` goes high. `bus_wait_n` stays high throughout writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_adv_n | input | 1 | Address-valid strobe, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_ad_in | input | HALF_W | Shared address/data path, inbound |
| bus_ad_out | output | HALF_W | Shared path, value driven on reads |
| bus_ad_oe | output | 1 | Drive enable for the shared path |
| bus_wait_n | output | 1 | Wait, active low |
| reg_idx | output | IDX_W | Internal register index |
| reg_wdata | output | 2*HALF_W | Internal write word |
| reg_wr | output | 1 | Internal write strobe |
| reg_rd | output | 1 | Internal read strobe |
| reg_rdata | input | 2*HALF_W | Internal read word |

## Verification
The bench checks that the two write halves are not swapped or taken one beat late; either fault corrupts the word seen by the internal side. On reads it counts the wait cycles against the latency. A bridge that releases wait early would put stale data on the path, and one that forgets to release it would stall the master. It also looks for three faults. The first is a non-matching block that still fires a strobe or drives the path. The second is an access aborted by chip select that leaves wait low. The third is a second address strobe inside one chip-select period that produces a stray write.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_LO,
    ST_WR_HI,
    ST_RD_WAIT,
    ST_RD_LO,
    ST_RD_HI,
    ST_HOLD
  } bus_state_e;
endpackage

// File: rtl/mbs_addr_decode.sv
module mbs_addr_decode #(
  parameter int HALF_W = 16,
  parameter int BLK_W  = 12,
  parameter int IDX_W  = 2,
  parameter logic [BLK_W-1:0] BLOCK_ID = 12'h321
) (
  input  logic [HALF_W-1:2]  addr_in,
  output logic               hit,
  output logic [IDX_W-1:0]   idx
);
  localparam int BLK_LO = HALF_W - BLK_W;

  always_comb begin
    hit = (addr_in[HALF_W-1:BLK_LO] == BLOCK_ID);
    idx = addr_in[IDX_W+1:2];
  end
endmodule

// File: rtl/mbs_wr_pack.sv
module mbs_wr_pack #(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cap_lo,
  input  logic                  cap_hi,
  input  logic [HALF_W-1:0]     half_in,
  output logic [2*HALF_W-1:0]   word_out,
  output logic                  strobe
);
  logic [HALF_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q     <= '0;
      word_out <= '0;
      strobe   <= 1'b0;
    end else begin
      strobe <= 1'b0;
      if (cap_lo) lo_q <= half_in;
      if (cap_hi) begin
        word_out <= {half_in, lo_q};
        strobe   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mbs_rd_split.sv
module mbs_rd_split #(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic                  advance,
  input  logic [2*HALF_W-1:0]   word_in,
  output logic [HALF_W-1:0]     half_out
);
  logic [HALF_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q     <= '0;
      half_out <= '0;
    end else if (load) begin
      hi_q     <= word_in[2*HALF_W-1:HALF_W];
      half_out <= word_in[HALF_W-1:0];
    end else if (advance) begin
      half_out <= hi_q;
    end
  end
endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave
  import mbs_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int BLK_W  = 12,
  parameter int IDX_W  = 2,
  parameter logic [BLK_W-1:0] BLOCK_ID = 12'h321,
  parameter int RD_LAT = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_cs_n,
  input  logic                  bus_adv_n,
  input  logic                  bus_we_n,
  input  logic                  bus_oe_n,
  input  logic [HALF_W-1:0]     bus_ad_in,
  output logic [HALF_W-1:0]     bus_ad_out,
  output logic                  bus_ad_oe,
  output logic                  bus_wait_n,
  output logic [IDX_W-1:0]      reg_idx,
  output logic [2*HALF_W-1:0]   reg_wdata,
  output logic                  reg_wr,
  output logic                  reg_rd,
  input  logic [2*HALF_W-1:0]   reg_rdata
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int CNT_W  = (RD_LAT < 2) ? 1 : $clog2(RD_LAT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RD_LAT - 1);

  bus_state_e       state_q;
  logic [CNT_W-1:0] lat_q;
  logic             drive_q;
  logic             addr_hit;
  logic [IDX_W-1:0] addr_idx;
  logic             active;
  logic             rd_load;
  logic             rd_next;
  logic             wr_lo;
  logic             wr_hi;

  mbs_addr_decode #(
    .HALF_W(HALF_W), .BLK_W(BLK_W), .IDX_W(IDX_W), .BLOCK_ID(BLOCK_ID)
  ) u_dec (
    .addr_in (bus_ad_in[HALF_W-1:2]),
    .hit     (addr_hit),
    .idx     (addr_idx)
  );

  always_comb begin
    active  = !bus_cs_n;
    rd_load = active && (state_q == ST_RD_WAIT) && (lat_q == CNT_LAST);
    rd_next = active && (state_q == ST_RD_LO);
    wr_lo   = active && (state_q == ST_WR_LO);
    wr_hi   = active && (state_q == ST_WR_HI);
  end

  mbs_wr_pack #(.HALF_W(HALF_W)) u_wr (
    .clk      (clk),
    .rst      (rst),
    .cap_lo   (wr_lo),
    .cap_hi   (wr_hi),
    .half_in  (bus_ad_in),
    .word_out (reg_wdata),
    .strobe   (reg_wr)
  );

  mbs_rd_split #(.HALF_W(HALF_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .load     (rd_load),
    .advance  (rd_next),
    .word_in  (reg_rdata[WORD_W-1:0]),
    .half_out (bus_ad_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      lat_q      <= '0;
      drive_q    <= 1'b0;
      bus_wait_n <= 1'b1;
      reg_rd     <= 1'b0;
      reg_idx    <= '0;
    end else begin
      reg_rd <= 1'b0;
      if (!active) begin
        state_q    <= ST_IDLE;
        drive_q    <= 1'b0;
        bus_wait_n <= 1'b1;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (!bus_adv_n) begin
              if (addr_hit) begin
                reg_idx <= addr_idx;
                if (!bus_we_n) begin
                  state_q <= ST_WR_LO;
                end else begin
                  state_q    <= ST_RD_WAIT;
                  reg_rd     <= 1'b1;
                  bus_wait_n <= 1'b0;
                  lat_q      <= '0;
                end
              end else begin
                state_q <= ST_HOLD;
              end
            end
          end
          ST_WR_LO:   state_q <= ST_WR_HI;
          ST_WR_HI:   state_q <= ST_HOLD;
          ST_RD_WAIT: begin
            if (lat_q == CNT_LAST) begin
              state_q    <= ST_RD_LO;
              bus_wait_n <= 1'b1;
              drive_q    <= 1'b1;
            end else begin
              lat_q <= lat_q + 1'b1;
            end
          end
          ST_RD_LO:   state_q <= ST_RD_HI;
          ST_RD_HI: begin
            state_q <= ST_HOLD;
            drive_q <= 1'b0;
          end
          default:    state_q <= ST_HOLD;
        endcase
      end
    end
  end

  assign bus_ad_oe = drive_q && !bus_oe_n && !bus_cs_n;
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker (
  input logic clk,
  input logic rst,
  input logic bus_cs_n,
  input logic bus_ad_oe,
  input logic bus_wait_n,
  input logic reg_wr,
  input logic reg_rd
);
  // R3
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> !reg_wr);

  // R4
  rd_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> !reg_rd);

  // R5
  wait_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_wait_n) |-> reg_rd);

  // R7
  drive_after_wait_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ad_oe |-> bus_wait_n);

  // R9
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_cs_n) |-> (bus_wait_n && !reg_wr && !reg_rd));

  // R10
  write_no_wait_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> bus_wait_n);
endmodule

bind mux_bus_slave mbs_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_cs_n   (bus_cs_n),
  .bus_ad_oe  (bus_ad_oe),
  .bus_wait_n (bus_wait_n),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd)
);

// File: tb/tb_mux_bus_slave.sv
module tb_mux_bus_slave;
  localparam int RD_LAT = 2;
  localparam logic [11:0] BLK = 12'h321;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_cs_n = 1'b1, bus_adv_n = 1'b1, bus_we_n = 1'b1, bus_oe_n = 1'b1;
  logic [15:0] bus_ad_in = '0;
  logic [15:0] bus_ad_out;
  logic        bus_ad_oe, bus_wait_n;
  logic [1:0]  reg_idx;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_wr, reg_rd;

  logic [31:0] regfile [4];
  logic [31:0] model   [4];

  typedef struct packed { logic [1:0] idx; logic [31:0] data; } wr_item_t;
  wr_item_t exp_q[$];

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  assign reg_rdata = regfile[reg_idx];

  mux_bus_slave #(.BLOCK_ID(BLK), .RD_LAT(RD_LAT)) dut (
    .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_adv_n(bus_adv_n),
    .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n), .bus_ad_in(bus_ad_in),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_wait_n(bus_wait_n),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: pops expected writes as the internal strobe appears
  always @(negedge clk) begin
    if (!rst && reg_wr) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8/R10 stray write", {30'd0, reg_idx}, 32'd0);
      end else begin
        wr_item_t it;
        it = exp_q.pop_front();
        check(reg_wdata == it.data, "R3 write word", reg_wdata, it.data);
        check(reg_idx == it.idx, "R2 write index", 32'(reg_idx), 32'(it.idx));
      end
      regfile[reg_idx] = reg_wdata;
    end
  end

  task automatic do_write(input logic [11:0] blk, input logic [1:0] idx, input logic [31:0] data);
    bit hit;
    hit = (blk == BLK);
    if (hit) begin
      exp_q.push_back('{idx: idx, data: data});
      model[idx] = data;
    end
    @(negedge clk);
    bus_cs_n = 0; bus_adv_n = 0; bus_we_n = 0; bus_ad_in = {blk, idx, 2'b00};
    @(negedge clk);
    bus_adv_n = 1; bus_ad_in = data[15:0];
    check(bus_wait_n == 1'b1, "R10 wait during write", 32'(bus_wait_n), 32'd1);
    @(negedge clk);
    bus_ad_in = data[31:16];
    @(negedge clk);
    check(reg_wr == hit, "R3 strobe timing", 32'(reg_wr), 32'(hit));
    check(!bus_ad_oe, "R7 no drive on write", 32'(bus_ad_oe), 32'd0);
    @(negedge clk);
    check(!reg_wr, "R3 strobe width", 32'(reg_wr), 32'd0);
    bus_cs_n = 1; bus_we_n = 1; bus_ad_in = '0;
    @(negedge clk);
  endtask

  task automatic do_read(input logic [11:0] blk, input logic [1:0] idx, input bit oe_low);
    bit hit;
    logic [15:0] lo, hi;
    logic [31:0] exp;
    hit = (blk == BLK);
    exp = model[idx];
    @(negedge clk);
    bus_cs_n = 0; bus_adv_n = 0; bus_we_n = 1; bus_oe_n = 1; bus_ad_in = {blk, idx, 2'b00};
    @(negedge clk);
    bus_adv_n = 1; bus_oe_n = !oe_low; bus_ad_in = '0;
    check(reg_rd == hit, "R4 read strobe", 32'(reg_rd), 32'(hit));
    check(bus_wait_n == !hit, "R5/R8 wait after address", 32'(bus_wait_n), 32'(!hit));
    if (hit) check(reg_idx == idx, "R2 read index", 32'(reg_idx), 32'(idx));
    for (int k = 1; k < RD_LAT; k++) begin
      @(negedge clk);
      check(bus_wait_n == !hit, "R5 wait held", 32'(bus_wait_n), 32'(!hit));
      check(!reg_rd, "R4 read strobe width", 32'(reg_rd), 32'd0);
      check(!bus_ad_oe, "R7 no drive in wait", 32'(bus_ad_oe), 32'd0);
    end
    @(negedge clk);
    check(bus_wait_n == 1'b1, "R5 wait released", 32'(bus_wait_n), 32'd1);
    check(bus_ad_oe == (hit && oe_low), "R7 drive low beat", 32'(bus_ad_oe), 32'(hit && oe_low));
    lo = bus_ad_out;
    @(negedge clk);
    check(bus_ad_oe == (hit && oe_low), "R7 drive high beat", 32'(bus_ad_oe), 32'(hit && oe_low));
    hi = bus_ad_out;
    if (hit) check({hi, lo} == exp, "R6 read word", {hi, lo}, exp);
    @(negedge clk);
    check(!bus_ad_oe, "R7 drive off after beats", 32'(bus_ad_oe), 32'd0);
    bus_cs_n = 1; bus_oe_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin regfile[i] = '0; model[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check(bus_wait_n == 1'b1, "R1 wait", 32'(bus_wait_n), 32'd1);
    check(!bus_ad_oe, "R1 drive", 32'(bus_ad_oe), 32'd0);
    check(!reg_wr && !reg_rd, "R1 strobes", {30'd0, reg_wr, reg_rd}, 32'd0);

    do_write(BLK, 2'd0, 32'hAA55A5A5);
    do_write(BLK, 2'd1, 32'h11221212);
    do_write(BLK, 2'd3, 32'h00010001);
    do_read(BLK, 2'd0, 1'b1);
    do_read(BLK, 2'd1, 1'b1);
    do_read(BLK, 2'd3, 1'b1);
    do_read(BLK, 2'd2, 1'b1);

    // R8 non-matching block: write dropped, read quiet
    do_write(12'h320, 2'd2, 32'hDEADBEEF);
    do_read(BLK, 2'd2, 1'b1);
    do_read(12'h322, 2'd0, 1'b1);

    // R7 output enable high keeps path released
    do_read(BLK, 2'd0, 1'b0);

    // R9 abort during wait
    @(negedge clk);
    bus_cs_n = 0; bus_adv_n = 0; bus_we_n = 1; bus_ad_in = {BLK, 2'd0, 2'b00};
    @(negedge clk);
    bus_adv_n = 1; bus_oe_n = 0;
    check(bus_wait_n == 1'b0, "R9 wait before abort", 32'(bus_wait_n), 32'd0);
    bus_cs_n = 1; bus_oe_n = 1;
    @(negedge clk);
    check(bus_wait_n == 1'b1, "R9 wait after abort", 32'(bus_wait_n), 32'd1);
    check(!bus_ad_oe, "R9 drive after abort", 32'(bus_ad_oe), 32'd0);
    do_write(BLK, 2'd2, 32'h12345678);
    do_read(BLK, 2'd2, 1'b1);

    // R10 second address strobe inside one select period is ignored
    exp_q.push_back('{idx: 2'd1, data: 32'hFFFF0000});
    model[1] = 32'hFFFF0000;
    @(negedge clk);
    bus_cs_n = 0; bus_adv_n = 0; bus_we_n = 0; bus_ad_in = {BLK, 2'd1, 2'b00};
    @(negedge clk); bus_adv_n = 1; bus_ad_in = 16'h0000;
    @(negedge clk); bus_ad_in = 16'hFFFF;
    @(negedge clk); bus_adv_n = 0; bus_ad_in = {BLK, 2'd2, 2'b00};
    @(negedge clk); bus_adv_n = 1; bus_ad_in = 16'h5555;
    @(negedge clk); bus_ad_in = 16'hAAAA;
    @(negedge clk);
    @(negedge clk);
    check(reg_idx == 2'd1, "R10 index kept", 32'(reg_idx), 32'd1);
    bus_cs_n = 1; bus_we_n = 1;
    @(negedge clk);
    do_read(BLK, 2'd1, 1'b1);
    do_read(BLK, 2'd2, 1'b1);

    check(exp_q.size() == 0, "R3 all writes seen", 32'(exp_q.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule